// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It fetches the word at the program counter from an internal instruction ROM, decodes it, reads two source registers, runs the ALU, touches the internal data memory, and writes back the result. All of this happens in the same cycle. The PC, the register file and the data memory share one rising clock edge. Instruction and data memory reads are combinational. The supported set is register-register add, subtract, AND, OR and signed set-less-than, plus word load, word store and branch-if-equal.

The program and the initial data image are parameters of the top module. A testbench, or an enclosing design, picks both when it instantiates the core. The only outputs are debug pins: the current PC and a trace of register writes. The trace is a valid-only stream. It has no ready signal, because a single-cycle core cannot stall, so an observer must sample it on every cycle that valid is high. A beat describes the register write that the next rising edge commits.

Top module: `scp_core`

## Requirements
- R1: While `rst` is high, `dbg_pc` is 0 at every clock edge and `dbg_wb_valid` is 0. After `rst` falls, the first instruction executed is the one at byte address 0. Reset also clears every register to zero and reloads the data memory from its initial image.
- R2: Every instruction other than a taken branch advances `dbg_pc` by 4. The PC is a byte address, and its two low bits are always zero.
- R3: Opcode 0x00 selects a register-register operation, with fields rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 0x20 writes R[rs]+R[rt] to rd and funct 0x22 writes R[rs]-R[rt] to rd. Both wrap modulo 2^32.
- R4: Funct 0x24 writes R[rs] AND R[rt] to rd, and funct 0x25 writes R[rs] OR R[rt] to rd.
- R5: Funct 0x2A writes 1 to rd when R[rs] is less than R[rt] as signed numbers, and writes 0 otherwise.
- R6: Opcode 0x23 (load word) writes register rt with the data word at byte address R[rs] plus the sign-extended imm16[15:0]. The word index is taken from address bits above bit 1, so negative offsets work.
- R7: Opcode 0x2B (store word) writes R[rt] to the data word at R[rs] plus the sign-extended imm16. A later load returns that value. The store writes no register.
- R8: Opcode 0x04 (branch-if-equal) sets the next PC to PC+4+sext(imm16)*4 when R[rs] equals R[rt], and to PC+4 otherwise. Negative offsets branch backwards. The branch writes neither registers nor memory.
- R9: Register 0 always reads as zero. A write that targets register 0 is discarded and is not reported on the trace.
- R10: An unknown opcode, or opcode 0x00 with an unknown funct, acts as a no-op. It writes no register, writes no memory, and advances the PC by 4.
- R11: In each cycle, `dbg_wb_valid`, `dbg_wb_reg` and `dbg_wb_data` give the register number and the value that the next rising edge writes, and they depend only on the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wb_valid | output | 1 | A register write commits at the next edge (valid-only, no back-pressure) |
| dbg_wb_reg | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The assertions check on every cycle that:
- the PC stays word-aligned;
- the PC advances by exactly 4 whenever no branch was taken;
- the PC returns to zero after a reset cycle;
- register 0 reads as zero and never shows up on the trace;
- the decoder never raises more than one of register write, memory write and branch;
- set-less-than produces only 0 or 1.

The values that come out of the ALU and the memories can only be shown by the bench's program. That program covers several things:
- loads with a negative offset;
- a store followed by a load of the same word;
- signed comparison across zero;
- a write aimed at register 0 and then read back;
- unknown encodings;
- branches that are taken, not taken, and that go backwards.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN     = 32;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    wb_from_mem;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_we: 1'b0, mem_we: 1'b0, wb_from_mem: 1'b0, dst_is_rd: 1'b0,
             b_is_imm: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.b_is_imm    = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_we   = 1'b1;
        ctrl.b_is_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch})); // R10
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra_addr,
  output logic [XLEN-1:0]   ra_data,
  input  logic [REG_AW-1:0] rb_addr,
  output logic [XLEN-1:0]   rb_data,
  input  logic              we,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data
);
  logic [XLEN-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we && wr_addr != '0) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  assign ra_data = (ra_addr == '0) ? '0 : regs_q[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : regs_q[rb_addr];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rb_addr == '0) |-> (rb_data == '0)); // R9
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  AST_SLT_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SLT) |-> (y[XLEN-1:1] == '0)); // R5
endmodule

// File: rtl/scp_dmem.sv
module scp_dmem
  import scp_pkg::*;
#(
  parameter int              DEPTH = 64,
  parameter logic [XLEN-1:0] INIT [DEPTH] = '{default: '0},
  localparam int             IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] addr,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem_q [DEPTH];
  logic [IW-1:0]   idx;
  logic            unused_addr;

  assign idx         = addr[IW+1:2];
  assign unused_addr = ^{addr[XLEN-1:IW+2], addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT[i];
    end else if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int              IMEM_DEPTH = 64,
  parameter int              DMEM_DEPTH = 64,
  parameter logic [XLEN-1:0] PROGRAM   [IMEM_DEPTH] = '{default: '0},
  parameter logic [XLEN-1:0] DATA_INIT [DMEM_DEPTH] = '{default: '0}
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wb_valid,
  output logic [REG_AW-1:0] dbg_wb_reg,
  output logic [XLEN-1:0]   dbg_wb_data
);
  localparam int IIW = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;

  logic [XLEN-1:0]   pc_q, pc_seq, pc_next, instr;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_y, ld_data, wb_val;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, dst;
  logic              alu_zero, take_branch, unused_bits;
  ctrl_t             ctrl;

  // fetch
  assign instr   = PROGRAM[pc_q[IIW+1:2]];
  assign rs_f    = instr[25:21];
  assign rt_f    = instr[20:16];
  assign rd_f    = instr[15:11];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign unused_bits = ^{pc_q[XLEN-1:IIW+2], pc_q[1:0], instr[10:6]};

  scp_decode u_dec (
    .clk(clk), .rst(rst), .opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl)
  );

  assign dst = ctrl.dst_is_rd ? rd_f : rt_f;

  scp_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra_addr(rs_f), .ra_data(rs_val),
    .rb_addr(rt_f), .rb_data(rt_val),
    .we(ctrl.reg_we), .wr_addr(dst), .wr_data(wb_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

  scp_alu u_alu (
    .clk(clk), .rst(rst), .op(ctrl.alu_op),
    .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  scp_dmem #(.DEPTH(DMEM_DEPTH), .INIT(DATA_INIT)) u_dmem (
    .clk(clk), .rst(rst), .addr(alu_y), .we(ctrl.mem_we),
    .wdata(rt_val), .rdata(ld_data)
  );

  assign wb_val = ctrl.wb_from_mem ? ld_data : alu_y;

  // next PC
  assign take_branch = ctrl.branch && alu_zero;
  assign pc_seq      = pc_q + XLEN'(4);
  assign pc_next     = take_branch ? pc_seq + {imm_ext[XLEN-3:0], 2'b00} : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // debug trace
  assign dbg_pc       = pc_q;
  assign dbg_wb_valid = !rst && ctrl.reg_we && (dst != '0);
  assign dbg_wb_reg   = dst;
  assign dbg_wb_data  = wb_val;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    dbg_pc[1:0] == 2'b00); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(take_branch)) |-> (dbg_pc == $past(dbg_pc) + XLEN'(4))); // R2
  AST_RESET_PC: assert property (@(posedge clk)
    $past(rst) |-> (dbg_pc == '0)); // R1
  AST_NO_R0_TRACE: assert property (@(posedge clk) disable iff (rst)
    dbg_wb_valid |-> (dbg_wb_reg != '0)); // R9
endmodule

// File: tb/scp_core_test.sv
module scp_core_test;
  localparam logic [31:0] PROG [64] = '{
    0:  32'h8C010000, 1:  32'h8C020004, 2:  32'h00221820, 3:  32'h00222022,
    4:  32'h00222824, 5:  32'h00223025, 6:  32'h0041382A, 7:  32'h0022402A,
    8:  32'h00210020, 9:  32'hAC03000C, 10: 32'h8C09000C, 11: 32'h8C0B0010,
    12: 32'h8D6AFFF8, 13: 32'hFC221820, 14: 32'h00221821, 15: 32'h10220005,
    16: 32'h11230002, 17: 32'h00216020, 18: 32'h00216020, 19: 32'h00216820,
    20: 32'h00017020, 21: 32'h1000FFFF, default: 32'h0
  };
  localparam logic [31:0] DINIT [64] = '{
    0: 32'h5, 1: 32'hFFFFFFF0, 2: 32'h7, 4: 32'h10, default: 32'h0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wb_data;
  logic        dbg_wb_valid;
  logic [4:0]  dbg_wb_reg;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  scp_core #(.PROGRAM(PROG), .DATA_INIT(DINIT)) uut (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wb_valid(dbg_wb_valid),
    .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check the current cycle, then advance to the next sample point.
  task automatic step(input string req, input logic [31:0] pc, input bit v,
                      input logic [4:0] r, input logic [31:0] d);
    check({req, " pc"}, dbg_pc, pc);
    check({req, " wb_valid"}, {31'b0, dbg_wb_valid}, {31'b0, v});
    if (v) begin
      check({req, " wb_reg"}, {27'b0, dbg_wb_reg}, {27'b0, r});
      check({req, " wb_data"}, dbg_wb_data, d);
    end
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic test_reset();
    repeat (3) begin
      @(negedge clk); #1;
      check("R1 reset pc", dbg_pc, 32'h0);
      check("R1 reset wb_valid", {31'b0, dbg_wb_valid}, 32'h0);
    end
    @(negedge clk); rst = 1'b0; #1;
  endtask

  task automatic test_loads();
    step("R1 R6 lw r1", 32'd0, 1, 5'd1, 32'h5);
    step("R6 R11 lw r2", 32'd4, 1, 5'd2, 32'hFFFFFFF0);
  endtask

  task automatic test_alu();
    step("R3 add", 32'd8, 1, 5'd3, 32'hFFFFFFF5);
    step("R3 sub", 32'd12, 1, 5'd4, 32'h15);
    step("R4 and", 32'd16, 1, 5'd5, 32'h0);
    step("R4 or", 32'd20, 1, 5'd6, 32'hFFFFFFF5);
    step("R5 slt true", 32'd24, 1, 5'd7, 32'h1);
    step("R5 slt false", 32'd28, 1, 5'd8, 32'h0);
  endtask

  task automatic test_r0_write();
    step("R9 write r0 hidden", 32'd32, 0, 5'd0, 32'h0);
  endtask

  task automatic test_store_load();
    step("R7 sw no wb", 32'd36, 0, 5'd0, 32'h0);
    step("R7 load stored", 32'd40, 1, 5'd9, 32'hFFFFFFF5);
    step("R6 lw base", 32'd44, 1, 5'd11, 32'h10);
    step("R6 lw negative offset", 32'd48, 1, 5'd10, 32'h7);
  endtask

  task automatic test_unknown();
    step("R10 bad opcode", 32'd52, 0, 5'd0, 32'h0);
    step("R10 bad funct", 32'd56, 0, 5'd0, 32'h0);
  endtask

  task automatic test_branch();
    step("R8 beq not taken", 32'd60, 0, 5'd0, 32'h0);
    step("R8 beq taken", 32'd64, 0, 5'd0, 32'h0);
    step("R8 R2 target add", 32'd76, 1, 5'd13, 32'hA);
    step("R9 r0 reads zero", 32'd80, 1, 5'd14, 32'h5);
  endtask

  task automatic test_backward();
    step("R8 self loop", 32'd84, 0, 5'd0, 32'h0);
    step("R8 backward stays", 32'd84, 0, 5'd0, 32'h0);
    step("R8 backward again", 32'd84, 0, 5'd0, 32'h0);
  endtask

  initial begin
    test_reset();
    test_loads();
    test_alu();
    test_r0_write();
    test_store_load();
    test_unknown();
    test_branch();
    test_backward();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule